// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block decides when a sampling analog-to-digital converter acquires its input and when it converts. Before any conversion it raises a converter-clock request and waits for the acknowledge. When it is switched off, it pulses a flush to the downstream result store, and only then drops the clock request. The operating configuration is captured at the moment enable is requested: tracking or windowed mode, reference kind, sample-time code and trigger source. Changing the configuration inputs later has no effect until the next enable.

In tracking (asynchronous) mode the input is followed continuously while the block waits, and a trigger starts the conversion at once. In windowed (synchronous) mode the converter rests between conversions. A trigger then opens a sampling window of 2^code ticks of a sampling-clock enable, and the conversion follows the window. A trigger comes either from a one-cycle software strobe or from one timer event line picked by a select value.

The block drives a reference-keep-alive flag for idle periods, and marks the first result after each enable, because that result may be unreliable. Triggers that arrive while the block is busy are dropped and recorded in a sticky flag. The converter itself is a fixed-latency model that holds the input value present when the conversion starts.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset with en_req low, all outputs are 0. When en_req goes high, clk_req rises on the next clock edge. ready rises only on the edge after clk_ack has been seen high, and stays low for as long as clk_ack stays low.
- R2: When en_req drops while ready is high, the next edge lowers ready and raises fifo_flush for exactly one cycle, with clk_req still high. clk_req falls on the edge after that.
- R3: In windowed mode (cfg_async=0), the sampling output is high for exactly 2^code cycles of smp_tick. Codes below 3 behave as code 3 and codes above 15 behave as code 15. Cycles with smp_tick low do not advance the window.
- R4: In windowed mode, res_valid appears exactly 2^code + CONV_CYCLES edges after the edge that took the trigger, when smp_tick is held high. res_data equals the ana_in value present in the last sampling cycle.
- R5: In tracking mode (cfg_async=1), sampling is high while ready and waiting. A trigger starts the conversion on its own edge, and res_valid follows CONV_CYCLES edges later. res_data equals ana_in in the trigger cycle.
- R6: ref_on_idle is high only while running in windowed mode with the fixed reference (cfg_ref_rel=0) and a clamped code below 6. It is 0 in tracking mode, with the relative reference, and while disabled.
- R7: When the trigger select is 0, only sw_trig starts a conversion. A select of k (1..N_EV) additionally accepts timer_ev[k-1], and every other event line is ignored.
- R8: A trigger that arrives while sampling or converting does not disturb the operation in progress, and it sets missed_trig. missed_trig stays set until the next enable request.
- R9: res_valid is a single-cycle strobe. res_first is high with the first result after each enable and low with later results.
- R10: Configuration inputs are captured when enable is requested. Changing them while enabled has no effect.
- R11: Dropping en_req during a conversion cancels it, so no res_valid appears. Triggers while disabled start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Enable request |
| cfg_async | input | 1 | 1 = tracking mode, 0 = windowed mode |
| cfg_ref_rel | input | 1 | 1 = relative reference, 0 = fixed reference |
| cfg_smpl_code | input | CODE_W | Sample-window exponent code |
| cfg_trig_sel | input | SEL_W | 0 = software only, k = timer_ev[k-1] also |
| sw_trig | input | 1 | Software trigger strobe |
| timer_ev | input | N_EV | Timer event pulses |
| smp_tick | input | 1 | Sampling-clock enable |
| clk_ack | input | 1 | Converter clock acknowledge |
| ana_in | input | RES_W | Value seen by the converter model |
| clk_req | output | 1 | Converter clock request |
| fifo_flush | output | 1 | Result store flush pulse |
| ready | output | 1 | Clock granted, block running |
| ref_on_idle | output | 1 | Keep reference on while idle |
| sampling | output | 1 | Input being acquired |
| converting | output | 1 | Conversion in progress |
| res_valid | output | 1 | Result strobe |
| res_data | output | RES_W | Result value |
| res_first | output | 1 | First result since enable |
| missed_trig | output | 1 | Sticky dropped-trigger flag |

## Verification
The bench builds the block with N_EV=4 and CONV_CYCLES=5, and keeps the 12-bit result and the 3..15 code range. The short conversion and small select field let every event line and every trigger path be exercised quickly. The window lengths walked (8 to 1024 cycles, including a code clamped up to 3) make exact latency counts cheap. The reference threshold at 6 is probed from both sides.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PWR_OFF   = 2'd0,
    PWR_REQ   = 2'd1,
    PWR_ON    = 2'd2,
    PWR_FLUSH = 2'd3
  } pwr_state_e;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_SAMPLE  = 2'd1,
    SEQ_CONVERT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_seq_pwr.sv
module adc_seq_pwr
  import adc_seq_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int SEL_W    = 4,
  parameter int CODE_MIN = 3,
  parameter int CODE_MAX = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_req,
  input  logic              clk_ack,
  input  logic              cfg_async,
  input  logic              cfg_ref_rel,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic [SEL_W-1:0]  cfg_sel,
  output logic              clk_req,
  output logic              flush,
  output logic              ready,
  output logic              run,
  output logic              en_edge,
  output logic              lat_async,
  output logic              lat_ref_rel,
  output logic [CODE_W-1:0] lat_code,
  output logic [SEL_W-1:0]  lat_sel
);
  pwr_state_e state_q, state_d;
  logic [CODE_W-1:0] code_clamped;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PWR_OFF:   if (en_req) state_d = PWR_REQ;
      PWR_REQ:   if (!en_req) state_d = PWR_OFF;
                 else if (clk_ack) state_d = PWR_ON;
      PWR_ON:    if (!en_req) state_d = PWR_FLUSH;
      PWR_FLUSH: state_d = PWR_OFF;
      default:   state_d = PWR_OFF;
    endcase
  end

  always_comb begin
    if (cfg_code < CODE_W'(CODE_MIN))      code_clamped = CODE_W'(CODE_MIN);
    else if (cfg_code > CODE_W'(CODE_MAX)) code_clamped = CODE_W'(CODE_MAX);
    else                                   code_clamped = cfg_code;
  end

  assign en_edge = (state_q == PWR_OFF) && en_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PWR_OFF;
      lat_async   <= 1'b0;
      lat_ref_rel <= 1'b0;
      lat_code    <= CODE_W'(CODE_MIN);
      lat_sel     <= '0;
    end else begin
      state_q <= state_d;
      if (en_edge) begin
        lat_async   <= cfg_async;
        lat_ref_rel <= cfg_ref_rel;
        lat_code    <= code_clamped;
        lat_sel     <= cfg_sel;
      end
    end
  end

  assign clk_req = (state_q != PWR_OFF);
  assign flush   = (state_q == PWR_FLUSH);
  assign ready   = (state_q == PWR_ON);
  assign run     = ready && en_req;
endmodule

// File: rtl/adc_seq_window.sv
module adc_seq_window #(
  parameter int CODE_W   = 4,
  parameter int CODE_MAX = 15,
  localparam int CNT_W   = CODE_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic              win_last
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_m1;
  logic [CNT_W-1:0] all_ones;

  assign all_ones = '1;

  always_comb begin
    int shamt;
    shamt  = CODE_MAX - int'(code);
    len_m1 = all_ones >> shamt;
  end

  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end

  assign win_last = active && tick && (cnt_q == len_m1);
endmodule

// File: rtl/adc_seq_conv_stub.sv
module adc_seq_conv_stub #(
  parameter int RES_W       = 12,
  parameter int CONV_CYCLES = 4,
  localparam int CNT_W      = $clog2(CONV_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             start,
  input  logic [RES_W-1:0] din,
  input  logic             tag_in,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] dout,
  output logic             tag_out
);
  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] hold_q;
  logic             tag_q;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      tag_out <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done    <= 1'b0;
      tag_out <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        cnt_q  <= '0;
        hold_q <= din;
        tag_q  <= tag_in;
      end else if (busy) begin
        if (cnt_q == CNT_W'(CONV_CYCLES - 1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          dout    <= hold_q;
          tag_out <= tag_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_EV           = 8,
  parameter int RES_W          = 12,
  parameter int CODE_W         = 4,
  parameter int CODE_MIN       = 3,
  parameter int CODE_MAX       = 15,
  parameter int REF_IDLE_BELOW = 6,
  parameter int CONV_CYCLES    = 4,
  localparam int SEL_W         = $clog2(N_EV + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_req,
  input  logic              cfg_async,
  input  logic              cfg_ref_rel,
  input  logic [CODE_W-1:0] cfg_smpl_code,
  input  logic [SEL_W-1:0]  cfg_trig_sel,
  input  logic              sw_trig,
  input  logic [N_EV-1:0]   timer_ev,
  input  logic              smp_tick,
  input  logic              clk_ack,
  input  logic [RES_W-1:0]  ana_in,
  output logic              clk_req,
  output logic              fifo_flush,
  output logic              ready,
  output logic              ref_on_idle,
  output logic              sampling,
  output logic              converting,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic              res_first,
  output logic              missed_trig
);
  logic              run, en_edge;
  logic              lat_async, lat_ref_rel;
  logic [CODE_W-1:0] lat_code;
  logic [SEL_W-1:0]  lat_sel;
  logic [N_EV-1:0]   ev_hit;
  logic              trig, win_last, conv_start, conv_busy;
  logic              first_pend_q;
  seq_state_e        seq_q, seq_d;

  adc_seq_pwr #(
    .CODE_W(CODE_W), .SEL_W(SEL_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)
  ) u_pwr (
    .clk(clk), .rst(rst), .en_req(en_req), .clk_ack(clk_ack),
    .cfg_async(cfg_async), .cfg_ref_rel(cfg_ref_rel),
    .cfg_code(cfg_smpl_code), .cfg_sel(cfg_trig_sel),
    .clk_req(clk_req), .flush(fifo_flush), .ready(ready), .run(run),
    .en_edge(en_edge), .lat_async(lat_async), .lat_ref_rel(lat_ref_rel),
    .lat_code(lat_code), .lat_sel(lat_sel)
  );

  for (genvar g = 0; g < N_EV; g++) begin : g_ev
    assign ev_hit[g] = timer_ev[g] && (lat_sel == SEL_W'(g + 1));
  end

  assign trig = run && (sw_trig || (|ev_hit));

  adc_seq_window #(
    .CODE_W(CODE_W), .CODE_MAX(CODE_MAX)
  ) u_win (
    .clk(clk), .rst(rst), .active(seq_q == SEQ_SAMPLE),
    .tick(smp_tick), .code(lat_code), .win_last(win_last)
  );

  always_comb begin
    seq_d      = seq_q;
    conv_start = 1'b0;
    if (!run) begin
      seq_d = SEQ_IDLE;
    end else begin
      case (seq_q)
        SEQ_IDLE: if (trig) begin
          if (lat_async) begin
            seq_d      = SEQ_CONVERT;
            conv_start = 1'b1;
          end else begin
            seq_d = SEQ_SAMPLE;
          end
        end
        SEQ_SAMPLE: if (win_last) begin
          seq_d      = SEQ_CONVERT;
          conv_start = 1'b1;
        end
        SEQ_CONVERT: if (res_valid) seq_d = SEQ_IDLE;
        default: seq_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q        <= SEQ_IDLE;
      missed_trig  <= 1'b0;
      first_pend_q <= 1'b0;
      ref_on_idle  <= 1'b0;
    end else begin
      seq_q <= seq_d;
      if (en_edge)                             missed_trig <= 1'b0;
      else if (trig && (seq_q != SEQ_IDLE))    missed_trig <= 1'b1;
      if (en_edge)         first_pend_q <= 1'b1;
      else if (conv_start) first_pend_q <= 1'b0;
      ref_on_idle <= run && !lat_async && !lat_ref_rel &&
                     (lat_code < CODE_W'(REF_IDLE_BELOW));
    end
  end

  adc_seq_conv_stub #(
    .RES_W(RES_W), .CONV_CYCLES(CONV_CYCLES)
  ) u_conv (
    .clk(clk), .rst(rst), .abort(!run), .start(conv_start),
    .din(ana_in), .tag_in(first_pend_q), .busy(conv_busy),
    .done(res_valid), .dout(res_data), .tag_out(res_first)
  );

  assign converting = (seq_q == SEQ_CONVERT) && conv_busy;
  assign sampling   = (seq_q == SEQ_SAMPLE) ||
                      ((seq_q == SEQ_IDLE) && ready && lat_async);
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic clk_ack,
  input logic clk_req,
  input logic fifo_flush,
  input logic ready,
  input logic ref_on_idle,
  input logic sampling,
  input logic converting,
  input logic res_valid,
  input logic res_first,
  input logic missed_trig
);
  // R1
  ready_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(clk_ack));
  // R2
  flush_holds_req_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |-> clk_req && !ready);
  // R2
  flush_then_drop_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |=> !clk_req && !fifo_flush);
  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sampling, converting, res_valid}));
  // R6
  ref_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    ref_on_idle |-> ready);
  // R8
  missed_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(missed_trig) |-> $rose(clk_req));
  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  // R9
  first_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    res_first |-> res_valid);
  // R11
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !sampling && !converting && !res_valid);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .clk_ack(clk_ack), .clk_req(clk_req),
  .fifo_flush(fifo_flush), .ready(ready), .ref_on_idle(ref_on_idle),
  .sampling(sampling), .converting(converting), .res_valid(res_valid),
  .res_first(res_first), .missed_trig(missed_trig)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;
  localparam int N_EV  = 4;
  localparam int CONV  = 5;
  localparam int RES_W = 12;
  localparam int SEL_W = $clog2(N_EV + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic en_req = 0, cfg_async = 0, cfg_ref_rel = 0, sw_trig = 0, smp_tick = 1, clk_ack = 0;
  logic [3:0] cfg_smpl_code = 4'd3;
  logic [SEL_W-1:0] cfg_trig_sel = '0;
  logic [N_EV-1:0] timer_ev = '0;
  logic [RES_W-1:0] ana_in = '0;
  logic clk_req, fifo_flush, ready, ref_on_idle, sampling, converting;
  logic res_valid, res_first, missed_trig;
  logic [RES_W-1:0] res_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.N_EV(N_EV), .CONV_CYCLES(CONV)) u_dut (
    .clk(clk), .rst(rst), .en_req(en_req), .cfg_async(cfg_async),
    .cfg_ref_rel(cfg_ref_rel), .cfg_smpl_code(cfg_smpl_code),
    .cfg_trig_sel(cfg_trig_sel), .sw_trig(sw_trig), .timer_ev(timer_ev),
    .smp_tick(smp_tick), .clk_ack(clk_ack), .ana_in(ana_in),
    .clk_req(clk_req), .fifo_flush(fifo_flush), .ready(ready),
    .ref_on_idle(ref_on_idle), .sampling(sampling), .converting(converting),
    .res_valid(res_valid), .res_data(res_data), .res_first(res_first),
    .missed_trig(missed_trig)
  );

  // code, expected window length
  localparam int VEC [6][2] = '{'{0, 8}, '{3, 8}, '{4, 16}, '{5, 32}, '{7, 128}, '{10, 1024}};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic enable(input bit as, input bit rel, input int code, input int sel);
    cfg_async = as; cfg_ref_rel = rel; cfg_smpl_code = 4'(code); cfg_trig_sel = SEL_W'(sel);
    en_req = 1; step();
    clk_ack = 1; step();
    step(); step();
  endtask

  task automatic disable_blk();
    en_req = 0; step(); step();
    clk_ack = 0; step();
  endtask

  // Software trigger, then count sampling cycles and edges to the result.
  task automatic run_trig(input int exp_w, input int exp_lat, input logic [RES_W-1:0] a,
                          input int exp_first);
    int n = 0, lat = 0;
    ana_in = a; sw_trig = 1; step(); sw_trig = 0;
    while (!res_valid && lat < 40000) begin
      if (sampling) n++;
      else ana_in = ~a;
      step(); lat++;
    end
    chk("R3 window", n, exp_w);
    chk("R4/R5 latency", lat, exp_lat);
    chk("R4/R5 data", int'(res_data), int'(a));
    chk("R9 first flag", int'(res_first), exp_first);
    step();
    chk("R9 single strobe", int'(res_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 reset outputs", int'({clk_req, fifo_flush, ready, ref_on_idle, sampling,
                                  converting, res_valid, res_first, missed_trig}), 0);
    rst = 0; step();

    // R1 handshake
    cfg_async = 0; cfg_smpl_code = 4'd3; cfg_trig_sel = '0;
    en_req = 1; step();
    chk("R1 clk_req rise", int'(clk_req), 1);
    chk("R1 ready waits", int'(ready), 0);
    step(); step(); step();
    chk("R1 ready held low without ack", int'(ready), 0);
    clk_ack = 1; step();
    chk("R1 ready after ack", int'(ready), 1);
    disable_blk();

    // R3 R4 vector walk
    for (int i = 0; i < 6; i++) begin
      enable(0, 0, VEC[i][0], 0);
      run_trig(VEC[i][1], VEC[i][1] + CONV, RES_W'(12'h100 + i * 7), 1);
      run_trig(VEC[i][1], VEC[i][1] + CONV, RES_W'(12'hA50 + i), 0);
      disable_blk();
    end

    // R5 tracking mode
    enable(1, 0, 3, 0);
    chk("R5 tracking while idle", int'(sampling), 1);
    chk("R6 off in tracking", int'(ref_on_idle), 0);
    run_trig(0, CONV, 12'h3C5, 1);
    chk("R5 tracking resumes", int'(sampling), 1);
    disable_blk();

    // R6 reference keep-alive
    enable(0, 0, 5, 0);
    chk("R6 fixed code 5", int'(ref_on_idle), 1);
    disable_blk();
    chk("R6 off when disabled", int'(ref_on_idle), 0);
    enable(0, 0, 6, 0);
    chk("R6 fixed code 6", int'(ref_on_idle), 0);
    disable_blk();
    enable(0, 1, 3, 0);
    chk("R6 relative ref", int'(ref_on_idle), 0);
    disable_blk();

    // R7 trigger select
    enable(0, 0, 3, 2);
    timer_ev = 4'b0101; step(); timer_ev = '0;
    chk("R7 unselected events ignored", int'(sampling), 0);
    timer_ev = 4'b0010; step(); timer_ev = '0;
    chk("R7 selected event starts", int'(sampling), 1);
    while (!res_valid) step();
    step();
    disable_blk();
    enable(0, 0, 3, 0);
    timer_ev = 4'b1111; step(); timer_ev = '0;
    chk("R7 select 0 ignores events", int'(sampling), 0);
    disable_blk();

    // R8 missed trigger
    begin
      int lat = 0;
      enable(0, 0, 4, 0);
      sw_trig = 1; step(); sw_trig = 0;
      step(); step(); step(); lat = 3;
      sw_trig = 1; step(); sw_trig = 0; lat++;
      chk("R8 missed set", int'(missed_trig), 1);
      while (!res_valid && lat < 1000) begin step(); lat++; end
      chk("R8 operation undisturbed", lat, 16 + CONV);
      step();
      chk("R8 no restart", int'(sampling), 0);
      chk("R8 sticky", int'(missed_trig), 1);
      disable_blk();
      chk("R8 sticky while off", int'(missed_trig), 1);
      enable(0, 0, 4, 0);
      chk("R8 cleared on enable", int'(missed_trig), 0);
      disable_blk();
    end

    // R3 stall of sampling ticks
    begin
      int n = 0;
      enable(0, 0, 3, 0);
      smp_tick = 0;
      sw_trig = 1; step(); sw_trig = 0;
      repeat (40) step();
      chk("R3 window holds without ticks", int'(sampling), 1);
      smp_tick = 1;
      while (sampling && n < 100) begin n++; step(); end
      chk("R3 remaining window", n, 8);
      while (!res_valid) step();
      step();
      disable_blk();
    end

    // R10 config captured at enable
    enable(0, 0, 3, 0);
    cfg_smpl_code = 4'd9; cfg_async = 1; cfg_ref_rel = 1;
    step();
    chk("R10 ref unaffected", int'(ref_on_idle), 1);
    run_trig(8, 8 + CONV, 12'h777, 1);
    disable_blk();

    // R11 abort and R2 shutdown order
    begin
      int nv = 0;
      enable(0, 0, 5, 0);
      sw_trig = 1; step(); sw_trig = 0;
      while (!converting) step();
      en_req = 0; step();
      chk("R2 flush pulse", int'(fifo_flush), 1);
      chk("R2 clk_req held during flush", int'(clk_req), 1);
      chk("R2 ready low", int'(ready), 0);
      step();
      chk("R2 flush single cycle", int'(fifo_flush), 0);
      chk("R2 clk_req dropped", int'(clk_req), 0);
      clk_ack = 0;
      repeat (30) begin if (res_valid) nv++; step(); end
      chk("R11 aborted conversion silent", nv, 0);
      sw_trig = 1; step(); sw_trig = 0; step();
      chk("R11 trigger while off", int'(sampling | converting | res_valid), 0);
    end

    summary();
  end
endmodule